// File: doc/BRIEF.md
# I2C Display Command Writer

This block is a single-master, write-only I2C transmitter for a small display controller. A client hands it one payload byte, together with a flag that marks it as a command or as display data. The block then runs a complete bus transaction on its own. It sends a start condition and the target address with the write bit cleared. Next it sends a control byte that tells the controller how to treat the payload, then the payload byte, and ends with a stop condition. The payload never goes out without the address in front of it.

Both bus lines are open-drain. Each output is a pull-low enable that the pad ring turns into an open-drain driver, and the block never drives a line high. The resolved SDA level comes back in through a two-flop synchronizer, and the target's acknowledge is read from it after every byte. Bit timing comes from a quarter-period divider of the system clock. With the default of 125 cycles per quarter, a 200 MHz clock gives an SCL period of 2.5 us.

Top module: `i2c_cmd_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `scl_oe`, `sda_oe`, `busy`, `done` and `nack_error` are 0 and `req_ready` is 1.
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while the block is idle with both lines released. `req_valid` is ignored while a transaction runs: the payload, the mode and the waveform do not change.
- R3: A transaction is sent in this order: start, then the address byte `{TARGET_ADDR, 0}` (0x78 by default), then the control byte, then the payload byte, then stop. Each byte goes out MSB first and is followed by a ninth SCL pulse with SDA released.
- R4: The control byte is 0x00 when `req_is_data` is 0 and 0x40 when it is 1.
- R5: `scl_oe` or `sda_oe` at 1 means the line is pulled low, and 0 means released. `sda_in` is the resolved line level.
- R6: Inside a byte, SDA changes only while SCL is pulled low, exactly QUARTER cycles after SCL was pulled low.
- R7: Start condition: both lines stay released for QUARTER cycles. SDA is then pulled low while SCL is still released, and SCL is pulled low 3*QUARTER cycles after that.
- R8: Stop condition: SCL is pulled low, SDA is pulled low QUARTER cycles later, and SCL is released QUARTER cycles after that. SDA is released 2*QUARTER cycles after SCL.
- R9: Every bus phase lasts QUARTER cycles, so one SCL period is 4*QUARTER system cycles. The first phase starts on the cycle after acceptance.
- R10: The acknowledge is taken from synchronized SDA at the end of the SCL-high half of the ninth pulse. A high level sets `nack_error` and goes straight to the stop condition. `nack_error` then holds until the next request is accepted, which clears it.
- R11: `busy` is 1 from the cycle after acceptance until the stop completes. In the cycle where it falls, `done` is 1 for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_is_data | input | 1 | 1: payload is display data, 0: payload is a command |
| req_byte | input | 8 | Payload byte |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Resolved SDA line level |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the stop completes |
| nack_error | output | 1 | Last transaction saw a NACK |

## Verification
A wrong bit counter, shift register or phase counter shows up on `scl_oe` or `sda_oe` within one quarter period of the fault. That is because the expected level of both enables is known for every single cycle of a transaction. A wrong acknowledge decision shows up within four phases: the stop sequence starts early or late, and `done` and `nack_error` appear at the wrong cycle or with the wrong value. A request taken while busy would corrupt the remaining bits of the byte being sent within one bit time.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BIT   = 2'd2,
    ST_STOP  = 2'd3
  } bus_state_e;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_BYTES = 3;
  localparam logic [BYTE_W-1:0] CTRL_CMD  = 8'h00;
  localparam logic [BYTE_W-1:0] CTRL_DATA = 8'h40;
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer #(
  parameter int unsigned QUARTER = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned QUARTER     = 125,
  parameter logic [6:0]  TARGET_ADDR = 7'h3C
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_is_data,
  input  logic [7:0]  req_byte,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in,
  output logic        busy,
  output logic        done,
  output logic        nack_error
);
  localparam int unsigned SHW      = BYTE_W * NUM_BYTES;
  localparam int unsigned SLOTS    = BYTE_W + 1;
  localparam int unsigned BIT_CW   = $clog2(SLOTS);
  localparam int unsigned BYTE_CW  = $clog2(NUM_BYTES);
  localparam logic [BIT_CW-1:0]  ACK_SLOT  = BIT_CW'(SLOTS - 1);
  localparam logic [BYTE_CW-1:0] LAST_BYTE = BYTE_CW'(NUM_BYTES - 1);

  logic rst_n, sda_s, tick, accept, ack_slot;

  bus_state_e           state_q, state_d;
  logic [1:0]           phase_q, phase_d;
  logic [BIT_CW-1:0]    bit_q, bit_d;
  logic [BYTE_CW-1:0]   byte_q, byte_d;
  logic [SHW-1:0]       shift_q, shift_d;
  logic                 scl_q, scl_d, sda_q, sda_d;
  logic                 nack_q, nack_d, done_q, done_d;

  i2c_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n)
  );

  i2c_sync2 #(.RST_VAL(1'b1)) sda_sync_i (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
  );

  i2c_quarter_timer #(.QUARTER(QUARTER)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE), .tick(tick)
  );

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign ack_slot = (bit_q == ACK_SLOT);

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    shift_d = shift_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    nack_d  = nack_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_START;
          phase_d = 2'd0;
          bit_d   = '0;
          byte_d  = '0;
          nack_d  = 1'b0;
          shift_d = {TARGET_ADDR, 1'b0,
                     (req_is_data ? CTRL_DATA : CTRL_CMD), req_byte};
        end
      end
      ST_START: begin
        if (tick) begin
          phase_d = phase_q + 2'd1;
          if (phase_q == 2'd0) sda_d = 1'b1;
          if (phase_q == 2'd3) begin
            state_d = ST_BIT;
            scl_d   = 1'b1;
          end
        end
      end
      ST_BIT: begin
        if (tick) begin
          phase_d = phase_q + 2'd1;
          case (phase_q)
            2'd0: sda_d = ack_slot ? 1'b0 : ~shift_q[SHW-1];
            2'd1: scl_d = 1'b0;
            2'd3: begin
              scl_d = 1'b1;
              if (ack_slot) begin
                bit_d = '0;
                if (sda_s) begin
                  nack_d  = 1'b1;
                  state_d = ST_STOP;
                end else if (byte_q == LAST_BYTE) begin
                  state_d = ST_STOP;
                end else begin
                  byte_d = byte_q + 1'b1;
                end
              end else begin
                bit_d   = bit_q + 1'b1;
                shift_d = {shift_q[SHW-2:0], 1'b0};
              end
            end
            default: ;
          endcase
        end
      end
      ST_STOP: begin
        if (tick) begin
          phase_d = phase_q + 2'd1;
          case (phase_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            2'd3: begin
              sda_d   = 1'b0;
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
            default: ;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 2'd0;
      bit_q   <= '0;
      byte_q  <= '0;
      shift_q <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      nack_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      shift_q <= shift_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      nack_q  <= nack_d;
      done_q  <= done_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign scl_oe     = scl_q;
  assign sda_oe     = sda_q;
  assign done       = done_q;
  assign nack_error = nack_q;

  // R6
  sda_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BIT && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!scl_oe && !sda_oe && !busy));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !nack_error));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && !sda_oe && $past(sda_oe) && !$past(scl_oe)));

  // R10
  nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_error && !(req_valid && req_ready)) |=> nack_error);
endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb_top;
  localparam int Q = 6;
  localparam logic [7:0] ADDR_BYTE = 8'h78;

  typedef struct packed { logic scl; logic sda; logic tlow; } exp_t;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic req_valid = 1'b0, req_is_data = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic tlow = 1'b0;
  logic req_ready, scl_oe, sda_oe, sda_in, busy, done, nack_error;

  int tests = 0, fails = 0;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  // R5: the line is low when either side pulls it
  assign sda_in = !(sda_oe || tlow);

  i2c_cmd_master #(.QUARTER(Q), .TARGET_ADDR(7'h3C)) dut_i (
    .clk(clk), .arst_n(arst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_byte(req_byte), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_in), .busy(busy), .done(done),
    .nack_error(nack_error)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_phase(input logic s, input logic d, input logic t);
    for (int i = 0; i < Q; i++) expq.push_back('{scl: s, sda: d, tlow: t});
  endtask

  // Reference model: per-cycle pull-low enables (R3, R6, R7, R8, R9)
  task automatic build(input logic [7:0] ctrl, input logic [7:0] pay, input int nack_at);
    logic [7:0] bytes [3];
    logic prev;
    bytes[0] = ADDR_BYTE; bytes[1] = ctrl; bytes[2] = pay;
    push_phase(0, 0, 0);                 // R7 bus free
    for (int i = 0; i < 3; i++) push_phase(0, 1, 0);
    prev = 1'b1;
    for (int b = 0; b < 3; b++) begin
      for (int i = 7; i >= 0; i--) begin
        push_phase(1, prev, 0);
        push_phase(1, ~bytes[b][i], 0);
        push_phase(0, ~bytes[b][i], 0);
        push_phase(0, ~bytes[b][i], 0);
        prev = ~bytes[b][i];
      end
      push_phase(1, prev, 0);
      push_phase(1, 0, b != nack_at);
      push_phase(0, 0, b != nack_at);
      push_phase(0, 0, b != nack_at);
      prev = 1'b0;
      if (b == nack_at) break;
    end
    push_phase(1, 0, 0);                 // R8 stop
    push_phase(1, 1, 0);
    push_phase(0, 1, 0);
    push_phase(0, 1, 0);
  endtask

  task automatic run_txn(input logic is_data, input logic [7:0] pay, input int nack_at,
                         input bit hold, input string tag);
    exp_t e;
    int n;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2", {7'd0, req_ready}, 8'd1);
    req_valid = 1'b1; req_is_data = is_data; req_byte = pay;
    build(is_data ? 8'h40 : 8'h00, pay, nack_at);   // R4 control byte
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      req_byte = ~pay; req_is_data = ~is_data;     // R2 ignored while busy
    end else begin
      req_valid = 1'b0;
    end
    n = 0;
    while (expq.size() > 0) begin
      e = expq.pop_front();
      tlow = e.tlow;
      chk({busy, req_ready, done, scl_oe, sda_oe} === {3'b100, e.scl, e.sda}, tag,
          {3'd0, busy, req_ready, done, scl_oe, sda_oe}, {3'd0, 3'b100, e.scl, e.sda});
      n++;
      if (hold && n == 200) req_valid = 1'b0;
      @(negedge clk);
    end
    tlow = 1'b0;
    // R11 done pulse, R10 flag
    chk({busy, req_ready, done, scl_oe, sda_oe} === 5'b01100, "R11",
        {3'd0, busy, req_ready, done, scl_oe, sda_oe}, 8'b01100);
    chk(nack_error === (nack_at < 3), "R10", {7'd0, nack_error}, {7'd0, nack_at < 3});
    @(negedge clk);
    chk(done === 1'b0, "R11", {7'd0, done}, 8'd0);
    chk(nack_error === (nack_at < 3), "R10", {7'd0, nack_error}, {7'd0, nack_at < 3});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({req_ready, busy, done, scl_oe, sda_oe, nack_error} === 6'b100000, "R1",
        {2'd0, req_ready, busy, done, scl_oe, sda_oe, nack_error}, 8'b00100000);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({req_ready, busy, done, scl_oe, sda_oe, nack_error} === 6'b100000, "R1",
        {2'd0, req_ready, busy, done, scl_oe, sda_oe, nack_error}, 8'b00100000);
    run_txn(1'b0, 8'hAF, 3, 1'b0, "R3 cmd AF");
    run_txn(1'b1, 8'h5A, 3, 1'b0, "R4 data 5A");
    run_txn(1'b0, 8'h00, 3, 1'b0, "R6 cmd 00");
    run_txn(1'b1, 8'hFF, 3, 1'b0, "R9 data FF");
    run_txn(1'b0, 8'hC3, 0, 1'b0, "R10 nack addr");
    repeat (10) @(negedge clk);
    chk(nack_error === 1'b1, "R10", {7'd0, nack_error}, 8'd1);
    run_txn(1'b0, 8'h81, 3, 1'b0, "R10 clear");
    run_txn(1'b1, 8'h3C, 2, 1'b0, "R10 nack payload");
    run_txn(1'b0, 8'hA5, 3, 1'b1, "R2 held valid");
    run_txn(1'b1, 8'h7E, 1, 1'b0, "R8 nack ctrl");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule